// File: doc/BRIEF.md
# Configurable Programmable-Array Logic Block

This block is a programmable sum-of-products logic array. The AND plane is programmable and the OR plane is fixed. Ten dedicated inputs and six pin-feedback signals make sixteen array signals. Every product term can connect to the true form, the complement form, or neither form of each array signal. Eight output pins each own eight product terms. Seven of them form a fixed OR that is inverted to give an active-low pin value. The eighth term drives that pin's output enable.

The connection pattern is loaded serially. While the load enable is high, one bit enters a 2048-bit configuration register on each rising edge of the configuration clock. A done flag marks the point at which a full image has been loaded. After that the array evaluates purely combinationally. Feedback is taken from the pin-input port of pins 1 to 6. This lets a disabled pin act as an extra input. An enabled pin can instead carry a helper term that the array uses in a second pass.

Top module: `pal_array`

## Requirements
- R1: After an asynchronous reset the configuration register is all zero. With an all-zero image, every term is empty, so `pin_out` is 8'h00, `pin_oe` is 8'hFF and `cfg_done` is 0.
- R2: On each rising `cfg_clk` edge with `cfg_en` high, `cfg_bit` shifts into the configuration register at bit 0 and the image moves one place toward the top bit. The first bit sent therefore ends at bit 2047. While `cfg_en` is low the register holds its value.
- R3: `cfg_done` is 0 until exactly 2048 bits have been shifted since reset. It then stays 1, including while a further image is shifted in.
- R4: Term t of pin o (t = 0..7) uses the 32-bit mask at register bits [32*(8*o+t) +: 32]. Mask bit 2*s connects the true form of array signal s. Mask bit 2*s+1 connects its complement. Signals 0..9 are `ded_in[0..9]`.
- R5: A term whose mask is zero evaluates to 1. A term that connects both forms of the same signal evaluates to 0.
- R6: `pin_out[o]` is the inverse of the OR of terms 0..6 of pin o.
- R7: `pin_oe[o]` equals term 7 of pin o.
- R8: Array signals 10..15 are `pin_in[1..6]`.
- R9: `pin_in[0]` and `pin_in[7]` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_rst_n | input | 1 | Asynchronous active-low reset of image and bit count |
| cfg_en | input | 1 | Shift enable |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_done | output | 1 | High once a full image has been loaded |
| ded_in | input | 10 | Dedicated array inputs |
| pin_in | input | 8 | Value seen on each pin; bits 1..6 feed the array |
| pin_out | output | 8 | Active-low sum-of-products value per pin |
| pin_oe | output | 8 | Output enable per pin |

## Verification
A single wrong configuration bit changes exactly one literal of one term. It becomes visible on a pin only for input patterns in which that literal decides the term and the term decides the OR. For this reason each loaded image is swept over all 1024 dedicated-input patterns, with several feedback patterns for each. A shift-order or count error moves or truncates the whole image. That shows up within the first vectors after the load, and as `cfg_done` rising one edge early or late.

// File: rtl/pal_array.sv
module pal_array #(
  parameter int N_DED = 10,
  parameter int N_PIN = 8,
  parameter int N_FB  = 6,
  parameter int FB_LO = 1,
  parameter int N_SUM = 7
) (
  input  logic             cfg_clk,
  input  logic             cfg_rst_n,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  output logic             cfg_done,
  input  logic [N_DED-1:0] ded_in,
  input  logic [N_PIN-1:0] pin_in,
  output logic [N_PIN-1:0] pin_out,
  output logic [N_PIN-1:0] pin_oe
);
  localparam int N_SIG    = N_DED + N_FB;
  localparam int MASK_W   = 2 * N_SIG;
  localparam int N_TERM   = N_SUM + 1;
  localparam int N_MASK   = N_PIN * N_TERM;
  localparam int CFG_BITS = N_MASK * MASK_W;
  localparam int CNT_W    = $clog2(CFG_BITS) + 1;
  localparam logic [N_PIN-1:0] FB_SEL = ((N_PIN'(1) << N_FB) - N_PIN'(1)) << FB_LO;

  logic [CFG_BITS-1:0] cfg_sr;
  logic [CNT_W-1:0]    bit_cnt;
  logic [N_SIG-1:0]    sig;
  logic [N_MASK-1:0]   term;
  logic [N_PIN-1:0]    pin_unused;

  always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n) begin
      cfg_sr  <= '0;
      bit_cnt <= '0;
    end else if (cfg_en) begin
      cfg_sr <= {cfg_sr[CFG_BITS-2:0], cfg_bit};
      if (bit_cnt != CNT_W'(CFG_BITS)) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign cfg_done   = (bit_cnt == CNT_W'(CFG_BITS));
  assign sig        = {pin_in[FB_LO+N_FB-1:FB_LO], ded_in};
  assign pin_unused = pin_in & ~FB_SEL;

  for (genvar t = 0; t < N_MASK; t++) begin : g_term
    logic [MASK_W-1:0] mask;
    logic [N_SIG-1:0]  lit_ok;
    assign mask = cfg_sr[t*MASK_W +: MASK_W];
    for (genvar s = 0; s < N_SIG; s++) begin : g_lit
      assign lit_ok[s] = (~mask[2*s] | sig[s]) & (~mask[2*s+1] | ~sig[s]);
    end
    assign term[t] = &lit_ok;
  end

  for (genvar o = 0; o < N_PIN; o++) begin : g_pin
    assign pin_out[o] = ~|term[o*N_TERM +: N_SUM];
    assign pin_oe[o]  = term[o*N_TERM + N_SUM];
  end

  // R2: shifting inserts the serial bit at the bottom of the image
  a_r2_shift_in: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    cfg_en |=> cfg_sr[0] == $past(cfg_bit));
  // R2: image frozen when not shifting
  a_r2_hold: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    !cfg_en |=> $stable(cfg_sr));
  // R3: done is sticky
  a_r3_done_sticky: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    cfg_done |=> cfg_done);
  // R3: done only rises after a shift
  a_r3_done_rise: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    $rose(cfg_done) |-> $past(cfg_en));
  // R3: count frozen when not shifting
  a_r3_count_hold: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    !cfg_en |=> $stable(bit_cnt));
endmodule

// File: tb/pal_array_test.sv
module pal_array_test;
  logic       cfg_clk = 1'b0;
  logic       cfg_rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_bit = 1'b0;
  logic       cfg_done;
  logic [9:0] ded_in = '0;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] img [64];

  pal_array uut (.*);

  always #10 cfg_clk = ~cfg_clk;

  initial begin
    #(20 * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit term_val(int o, int t, logic [9:0] d, logic [7:0] p);
    logic [15:0] s;
    logic [31:0] m;
    s = {p[6:1], d};           // R8 feedback signals 10..15
    m = img[8*o + t];          // R4 mask placement
    for (int k = 0; k < 16; k++) begin
      if (m[2*k] && !s[k]) return 1'b0;
      if (m[2*k+1] && s[k]) return 1'b0;
    end
    return 1'b1;               // R5 empty term is 1
  endfunction

  function automatic logic [15:0] model(logic [9:0] d, logic [7:0] p);
    logic [7:0] o_v, o_e;
    for (int o = 0; o < 8; o++) begin
      bit any = 1'b0;
      for (int t = 0; t < 7; t++) any |= term_val(o, t, d, p);
      o_v[o] = ~any;                 // R6
      o_e[o] = term_val(o, 7, d, p); // R7
    end
    return {o_e, o_v};
  endfunction

  function automatic logic [31:0] rand_mask();
    logic [31:0] m = '0;
    int n = $urandom % 4;
    for (int i = 0; i < n; i++) m[($urandom % 16) * 2 + ($urandom % 2)] = 1'b1;
    return m;
  endfunction

  task automatic load(input bit done_before);
    for (int i = 2047; i >= 0; i--) begin
      @(negedge cfg_clk);
      if (i == 0) chk(cfg_done == done_before, "R3 done after 2047 bits", cfg_done, done_before);
      cfg_en  = 1'b1;
      cfg_bit = img[i / 32][i % 32];
    end
    @(negedge cfg_clk);
    cfg_en = 1'b0;
    chk(cfg_done == 1'b1, "R3 done after 2048 bits", cfg_done, 1);
    for (int i = 0; i < 40; i++) begin
      @(negedge cfg_clk);
      cfg_bit = ~cfg_bit;      // R2 ignored while cfg_en low
    end
  endtask

  task automatic sweep(input string tag);
    logic [7:0] pv [4];
    logic [15:0] e;
    for (int i = 0; i < 4; i++) pv[i] = 8'($urandom);
    for (int d = 0; d < 1024; d++) begin
      for (int i = 0; i < 4; i++) begin
        ded_in = 10'(d);
        pin_in = pv[i];
        #2;
        e = model(ded_in, pin_in);
        chk({pin_oe, pin_out} == e, tag, {pin_oe, pin_out}, e);
      end
    end
  endtask

  initial begin
    logic [15:0] ref_o;
    #25;
    chk(pin_out == 8'h00, "R1 reset pin_out", pin_out, 0);
    chk(pin_oe == 8'hFF, "R1 reset pin_oe", pin_oe, 8'hFF);
    chk(cfg_done == 1'b0, "R1 reset cfg_done", cfg_done, 0);
    cfg_rst_n = 1'b1;

    for (int i = 0; i < 64; i++) img[i] = rand_mask();
    img[0] = 32'h0000_0003;                                 // R5 contradictory term
    for (int t = 1; t < 7; t++) img[t] = 32'h0000_0040;     // R4 true ded_in[3]
    img[7]  = 32'h0200_0000;                                // R8 complement of pin_in[3]
    img[63] = 32'h0;                                        // R5 empty enable
    load(1'b0);

    for (int d = 0; d < 16; d++) begin
      ded_in = 10'(d * 37);
      pin_in = 8'(d * 11);
      #2;
      chk(pin_out[0] == ~ded_in[3], "R4 pin0 literal", pin_out[0], ~ded_in[3]);
      chk(pin_oe[0] == ~pin_in[3], "R8 pin0 feedback enable", pin_oe[0], ~pin_in[3]);
      chk(pin_oe[7] == 1'b1, "R5 empty term", pin_oe[7], 1);
      ref_o = {pin_oe, pin_out};
      pin_in = pin_in ^ 8'h81;
      #2;
      chk({pin_oe, pin_out} == ref_o, "R9 pins 0 and 7 ignored", {pin_oe, pin_out}, ref_o);
    end
    sweep("R6 R7 sweep image 1");

    for (int i = 0; i < 64; i++) img[i] = rand_mask() | rand_mask();
    load(1'b1);
    sweep("R2 R6 R7 sweep image 2");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule